// File: doc/BRIEF.md
# Polyphase Decimating Analysis Filter Bank

This block is the filtering front end of a uniformly spaced channelizer. A single stream of real 12-bit two's complement samples enters one sample per accepted beat. A commutator deals each group of 16 consecutive samples across 16 sub-filters, one sample per sub-filter, so every sub-filter runs at one sixteenth of the input rate. Sub-filter `r` holds the polyphase branch `h(r + 16·n)`, `n = 0..13`, of a 224-tap lowpass prototype that is fixed at synthesis time.

Each sub-filter computes its 14-tap product sum on a folded schedule. A folding factor `FOLD` sets how many clocks one sub-filter output takes. Each sub-filter therefore needs `ceil(14/FOLD)` multipliers. Once the last sub-filter of a group has finished, the 16 results are sent out on one time-division-multiplexed bus, one word per clock in branch order 0..15. Each word carries its branch index, and a frame strobe marks branch 0, so a 16-point transform stage can consume the bus directly.

Top module: `pfb_decim`

## Requirements
- R1: A synchronous reset clears every sub-filter delay line and the commutator position. Output valid and frame are low after reset, and later outputs contain no contribution from samples accepted before the reset.
- R2: Within each group of 16 accepted samples (positions k = 0..15 since reset), the sample at position k is loaded into sub-filter 15-k. Branch 15 is loaded first and branch 0 last.
- R3: For group b, branch r outputs the sum over n = 0..13 of h(r+16n)·x(b-n, 15-r). Here x(g, k) is the sample at position k of group g, and it counts as zero for groups before reset. The prototype coefficient is h(i) = ((73·i) mod 251)·16 − 2000.
- R4: Each sum is rounded by adding 128 and shifting arithmetically right by 8 (floor). The result is then saturated to the signed 16-bit range [-32768, 32767].
- R5: Each group produces exactly 16 output words on consecutive clocks, with `out_idx` stepping 0,1,..,15. `out_frame` is high only on the word with index 0.
- R6: The word with index j becomes visible FOLD+1+j clocks after the clock edge that accepts the group's 16th sample. FOLD may range from 1 to 15.
- R7: A cycle with `in_valid` low changes no filter or commutator state. Idle gaps anywhere in the input stream leave every output value unchanged.
- R8: A reset asserted partway through a group discards that partial group. The next accepted sample again goes to branch 15, and no output word appears for the discarded samples.
- R9: `out_valid` is high only during the 16-word bursts, one burst per completed group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier, one sample accepted per high cycle |
| in_sample | input | 12 | Input sample, two's complement |
| out_valid | output | 1 | Qualifies every output word |
| out_frame | output | 1 | High on the branch 0 word of each burst |
| out_idx | output | 4 | Branch index of the current output word |
| out_data | output | 16 | Rounded, saturated branch output |

## Verification
The hardest condition to reach from the ports is saturation of every branch at once. It needs all 14 taps of each branch to add in the same direction, and that depends on the signs of coefficients that differ from tap to tap and branch to branch. The stimulus reaches it by feeding 14 groups in which each sample is full scale, with its sign matched to the coefficient it will meet in the final group's sum. The same pattern is then repeated with the signs inverted, to drive every branch to negative saturation. Idle gaps of varying length and a reset in the middle of a group are also driven, to show that the schedule and the output stream survive them unchanged.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

  localparam int PATHS    = 16;
  localparam int TAPS_PER = 14;
  localparam int SAMPLE_W = 12;
  localparam int COEF_W   = 12;
  localparam int WORD_W   = 16;
  localparam int SCALE_SH = 8;
  localparam int FOLD_DEF = 2;

  // Prototype lowpass coefficient for flat tap index i (synthesis-time constant).
  function automatic int proto_coef(input int i);
    return ((i * 73) % 251) * 16 - 2000;
  endfunction

  // Round half up by 2^sh, then clamp to a signed ow-bit range.
  function automatic longint round_sat(input longint v, input int sh, input int ow);
    longint r;
    longint hi;
    longint lo;
    r  = (v + (longint'(1) <<< (sh - 1))) >>> sh;
    hi = (longint'(1) <<< (ow - 1)) - 1;
    lo = -hi - 1;
    if (r > hi) return hi;
    if (r < lo) return lo;
    return r;
  endfunction

endpackage

// File: rtl/pfb_commutator.sv
module pfb_commutator #(
  parameter int M     = 16,
  parameter int IDX_W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic [M-1:0] load
);

  logic [IDX_W-1:0] slot;

  // Position k of a group feeds branch M-1-k.
  always_comb begin
    load = '0;
    load[IDX_W'(M - 1) - slot] = in_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
    end else if (in_valid) begin
      slot <= (slot == IDX_W'(M - 1)) ? '0 : slot + 1'b1;
    end
  end

endmodule

// File: rtl/pfb_branch.sv
module pfb_branch #(
  parameter int M     = 16,
  parameter int TAPS  = 14,
  parameter int FOLD  = 2,
  parameter int IN_W  = 12,
  parameter int C_W   = 12,
  parameter int ACC_W = 29,
  parameter int OUT_W = 16,
  parameter int SHIFT = 8,
  parameter int BR    = 0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] result,
  output logic                    done
);

  localparam int PER  = (TAPS + FOLD - 1) / FOLD;
  localparam int PH_W = (FOLD > 1) ? $clog2(FOLD) : 1;
  localparam int TW   = (TAPS > 1) ? $clog2(TAPS) : 1;

  logic signed [C_W-1:0]   cf [TAPS];
  logic signed [IN_W-1:0]  dl [TAPS];
  logic [PH_W-1:0]         phase;
  logic                    busy;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] part;
  logic signed [ACC_W-1:0] total;
  logic                    last_phase;

  // Constant branch coefficients: tap t uses prototype index BR + M*t.
  for (genvar t = 0; t < TAPS; t++) begin : g_coef
    assign cf[t] = C_W'(pfb_pkg::proto_coef(BR + M * t));
  end

  // Partial sum of the PER taps scheduled in this phase.
  always_comb begin
    int t;
    part = '0;
    for (int p = 0; p < PER; p++) begin
      t = int'(phase) * PER + p;
      if (t < TAPS) begin
        part = part + ACC_W'(cf[TW'(t)]) * ACC_W'(dl[TW'(t)]);
      end
    end
  end

  assign total      = acc + part;
  assign last_phase = (phase == PH_W'(FOLD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TAPS; i++) dl[i] <= '0;
      busy   <= 1'b0;
      phase  <= '0;
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        dl[0] <= din;
        for (int i = 1; i < TAPS; i++) dl[i] <= dl[i-1];
        busy  <= 1'b1;
        phase <= '0;
        acc   <= '0;
      end else if (busy) begin
        if (last_phase) begin
          result <= OUT_W'(pfb_pkg::round_sat(longint'(total), SHIFT, OUT_W));
          busy   <= 1'b0;
          done   <= 1'b1;
        end else begin
          acc   <= total;
          phase <= phase + 1'b1;
        end
      end
    end
  end

  // The folded schedule must finish before this branch's next sample.
  assert_sched_fits_R6: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);

endmodule

// File: rtl/pfb_tdm_emit.sv
module pfb_tdm_emit #(
  parameter int M     = 16,
  parameter int IDX_W = 4,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    trig,
  input  logic signed [OUT_W-1:0] res [M],
  output logic                    out_valid,
  output logic                    out_frame,
  output logic [IDX_W-1:0]        out_idx,
  output logic signed [OUT_W-1:0] out_data
);

  logic signed [OUT_W-1:0] hold [M];
  logic                    burst_end;

  assign burst_end = (out_idx == IDX_W'(M - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_frame <= 1'b0;
      out_idx   <= '0;
      out_data  <= '0;
      for (int i = 0; i < M; i++) hold[i] <= '0;
    end else if (trig) begin
      for (int i = 0; i < M; i++) hold[i] <= res[i];
      out_valid <= 1'b1;
      out_frame <= 1'b1;
      out_idx   <= '0;
      out_data  <= res[0];
    end else begin
      out_frame <= 1'b0;
      if (out_valid && !burst_end) begin
        out_idx  <= out_idx + 1'b1;
        out_data <= hold[out_idx + 1'b1];
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_frame_first_R5: assert property (@(posedge clk) disable iff (rst)
    out_frame |-> (out_valid && out_idx == '0));

  assert_idx_step_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !burst_end && !trig) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

  assert_burst_idle_R9: assert property (@(posedge clk) disable iff (rst)
    trig |-> (!out_valid || burst_end));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_frame));

endmodule

// File: rtl/pfb_decim.sv
module pfb_decim #(
  parameter int M     = pfb_pkg::PATHS,
  parameter int TAPS  = pfb_pkg::TAPS_PER,
  parameter int FOLD  = pfb_pkg::FOLD_DEF,
  parameter int IN_W  = pfb_pkg::SAMPLE_W,
  parameter int C_W   = pfb_pkg::COEF_W,
  parameter int OUT_W = pfb_pkg::WORD_W,
  parameter int SHIFT = pfb_pkg::SCALE_SH
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic signed [IN_W-1:0]            in_sample,
  output logic                              out_valid,
  output logic                              out_frame,
  output logic [$clog2(M)-1:0]              out_idx,
  output logic signed [OUT_W-1:0]           out_data
);

  localparam int IDX_W = $clog2(M);
  localparam int ACC_W = IN_W + C_W + $clog2(TAPS) + 1;

  logic [M-1:0]            branch_load;
  logic [M-1:0]            branch_done;
  logic signed [OUT_W-1:0] branch_res [M];

  pfb_commutator #(.M(M), .IDX_W(IDX_W)) u_comm (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .load     (branch_load)
  );

  for (genvar r = 0; r < M; r++) begin : g_branch
    pfb_branch #(
      .M(M), .TAPS(TAPS), .FOLD(FOLD), .IN_W(IN_W), .C_W(C_W),
      .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT), .BR(r)
    ) u_br (
      .clk    (clk),
      .rst    (rst),
      .load   (branch_load[r]),
      .din    (in_sample),
      .result (branch_res[r]),
      .done   (branch_done[r])
    );
  end

  // Branch 0 is loaded last in a group, so its completion releases the burst.
  pfb_tdm_emit #(.M(M), .IDX_W(IDX_W), .OUT_W(OUT_W)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .trig      (branch_done[0]),
    .res       (branch_res),
    .out_valid (out_valid),
    .out_frame (out_frame),
    .out_idx   (out_idx),
    .out_data  (out_data)
  );

  // At most one sample is accepted per clock and every schedule lasts FOLD clocks.
  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(branch_done));

endmodule

// File: tb/pfb_decim_bench.sv
module pfb_decim_bench;

  localparam int CLK_PERIOD = 10;
  localparam int B_FOLD     = 2;
  localparam int NMAX       = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic signed [11:0] in_sample = '0;
  logic        out_valid;
  logic        out_frame;
  logic [3:0]  out_idx;
  logic signed [15:0] out_data;

  pfb_decim #(.FOLD(B_FOLD)) u_pfb_decim (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_frame(out_frame), .out_idx(out_idx), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 0;

  int xs [NMAX];
  int nsamp = 0;
  int last_edge = 0;

  int cap_data [NMAX];
  int cap_idx  [NMAX];
  int cap_frm  [NMAX];
  int cap_cyc  [NMAX];
  int ncap = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && ncap < NMAX) begin
      cap_data[ncap] = int'(out_data);
      cap_idx[ncap]  = int'(out_idx);
      cap_frm[ncap]  = int'(out_frame);
      cap_cyc[ncap]  = cyc;
      ncap++;
    end
  end

  function automatic int ref_h(input int i);
    int v;
    v = i * 73;
    while (v >= 251) v -= 251;
    return 16 * v - 2000;
  endfunction

  function automatic int ref_round(input longint s);
    longint a;
    longint q;
    a = s + 128;
    if (a >= 0) q = a / 256;
    else q = -((-a + 255) / 256);
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  function automatic int ref_word(input int b, input int r);
    longint s;
    s = 0;
    for (int n = 0; n < 14; n++) begin
      if (b - n >= 0) s += longint'(ref_h(r + 16 * n)) * longint'(xs[(b - n) * 16 + 15 - r]);
    end
    return ref_round(s);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    nsamp = 0;
    ncap = 0;
  endtask

  task automatic push(input int s);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 12'(s);
    last_edge = cyc + 1;
    xs[nsamp] = s;
    nsamp++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic verify(input string tag);
    int blocks;
    blocks = nsamp / 16;
    check(ncap == blocks * 16, "R9 word count", ncap, blocks * 16);
    for (int j = 0; j < ncap && j < blocks * 16; j++) begin
      check(cap_idx[j] == j % 16, "R5 index order", cap_idx[j], j % 16);
      check(cap_frm[j] == ((j % 16 == 0) ? 1 : 0), "R5 frame strobe", cap_frm[j], (j % 16 == 0) ? 1 : 0);
      check(cap_data[j] == ref_word(j / 16, j % 16), tag, cap_data[j], ref_word(j / 16, j % 16));
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
    check(out_frame == 1'b0, "R1 frame after reset", int'(out_frame), 0);
  endtask

  task automatic t_latency();
    do_reset();
    for (int k = 0; k < 16; k++) push(100 * k - 700);
    idle(B_FOLD + 24);
    check(ncap == 16, "R9 one burst", ncap, 16);
    check(cap_cyc[0] == last_edge + B_FOLD + 1, "R6 first word latency", cap_cyc[0], last_edge + B_FOLD + 1);
    check(cap_cyc[15] == last_edge + B_FOLD + 16, "R6 last word latency", cap_cyc[15], last_edge + B_FOLD + 16);
    verify("R3 ramp group");
  endtask

  task automatic t_random();
    logic [15:0] lf;
    lf = 16'hACE1;
    do_reset();
    for (int i = 0; i < 20 * 16; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      push(int'($signed(lf[11:0])));
    end
    idle(B_FOLD + 24);
    verify("R3 random stream");
  endtask

  task automatic t_impulse();
    do_reset();
    // single nonzero at position 3 of group 0: only branch 12 responds (R2)
    for (int g = 0; g < 15; g++) begin
      for (int k = 0; k < 16; k++) push((g == 0 && k == 3) ? 1001 : 0);
    end
    idle(B_FOLD + 24);
    verify("R2 impulse routing");
    check(cap_data[12] == ref_round(longint'(ref_h(12)) * 1001), "R2 impulse branch 12",
          cap_data[12], ref_round(longint'(ref_h(12)) * 1001));
    check(cap_data[13] == 0, "R1 no prior history", cap_data[13], 0);
  endtask

  task automatic t_gaps();
    logic [15:0] lf;
    lf = 16'h1D2B;
    do_reset();
    for (int i = 0; i < 16 * 16; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      push(int'($signed(lf[11:0])));
      idle(int'(lf[15:14]));
    end
    idle(B_FOLD + 24);
    verify("R7 gapped stream");
  endtask

  task automatic t_sat(input int pol, input int target);
    int sg;
    do_reset();
    for (int g = 0; g < 14; g++) begin
      for (int k = 0; k < 16; k++) begin
        sg = (ref_h((15 - k) + 16 * (13 - g)) < 0) ? -1 : 1;
        push(pol * 2047 * sg);
      end
    end
    idle(B_FOLD + 24);
    verify("R4 full scale stream");
    for (int r = 0; r < 16; r++) begin
      check(cap_data[13 * 16 + r] == target, "R4 saturation", cap_data[13 * 16 + r], target);
    end
  endtask

  task automatic t_reset_mid();
    do_reset();
    for (int k = 0; k < 7; k++) push(300 + k);
    do_reset();
    for (int k = 0; k < 48; k++) push(k * 37 - 800);
    idle(B_FOLD + 24);
    verify("R8 restart after mid reset");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_latency();
    t_random();
    t_impulse();
    t_gaps();
    t_sat(1, 32767);
    t_sat(-1, -32768);
    t_reset_mid();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule